// File: doc/BRIEF.md
# Receive Frame Buffer Overwrite Guard

This block sits between the byte stream of a radio receiver and the air-side write port of a shared frame buffer. Reception keeps going for as long as the transceiver is in a receive state. Without the guard, every new frame would overwrite the one before it. When software turns protection on and the transceiver is in one of the two receive-on states, a completed frame that qualifies locks the buffer. Later frames from the air are then refused until software drops the enable bit. That gives software as long as it needs to read the stored frame.

Which frames qualify depends on the operating mode. In basic mode, a frame qualifies when its checksum is good. In extended mode, it qualifies when the receiver raises its end-of-receive event. The guard decides admission once per frame, at the frame-start strobe. A frame that is already being written always completes.

The air side is a valid/ready stream. `air_ready` is tied high, so the guard never applies back-pressure. A beat that is refused, or that falls beyond the buffer depth, is accepted and then discarded. The software write port is passed straight through to the buffer in the same cycle and is never gated.

Top module: `fbg_rx_guard`

## Requirements
- R1: After reset, `buf_locked`, `air_permit`, `frame_dropped`, `mem_air_we` and `frame_len` are all 0, and `air_ready` is 1.
- R2: Protection is active only when `prot_en`=1 and `trx_state` equals 5'h04 (plain receive) or 5'h0C (receive with auto-acknowledge). In any other state, `buf_locked` reads 0, every frame is admitted and each new frame overwrites the previous one.
- R3: With `ext_mode`=0 (basic) and protection active, an admitted frame whose `rx_eof` comes with `rx_crc_ok`=1 sets the lock. `buf_locked` rises one cycle after that `rx_eof`. With `rx_crc_ok`=0 the lock is not set.
- R4: With `ext_mode`=1 (extended) and protection active, the lock is set by `rx_end_evt`=1 at `rx_eof`, and `rx_crc_ok` is ignored.
- R5: A frame whose `rx_sof` arrives while `buf_locked`=1 is blocked. `air_permit` stays 0 and `mem_air_we` never rises for any of its beats.
- R6: A blocked frame raises `frame_dropped` for exactly one cycle, the cycle after its `rx_sof`. `frame_len` stays unchanged.
- R7: With `prot_en`=0, the lock clears at the next clock edge. Leaving the receive states suspends the lock (`buf_locked`=0, frames admitted). Returning to a receive state with `prot_en` still 1 restores it.
- R8: The software port `sw_we`/`sw_addr`/`sw_wdata` appears unchanged on `mem_sw_*` in the same cycle, whether or not the buffer is locked.
- R9: In an admitted frame, each beat with `air_valid`=1 writes `air_data` combinationally at addresses 0, 1, 2 and so on. Beats past DEPTH are discarded. At `rx_eof`, `frame_len` takes the number of beats written, capped at DEPTH, and shows it one cycle later.
- R10: Beats and `rx_eof` that arrive with no preceding `rx_sof` cause no buffer write, no lock and no change to `frame_len`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trx_state | input | 5 | Transceiver state code |
| ext_mode | input | 1 | 0 = basic (checksum) lock rule, 1 = extended (event) lock rule |
| prot_en | input | 1 | Software protection enable; 0 releases the lock |
| rx_sof | input | 1 | Frame-start strobe (carries no data) |
| rx_eof | input | 1 | Frame-end strobe (carries no data) |
| rx_crc_ok | input | 1 | Checksum valid, sampled with `rx_eof` |
| rx_end_evt | input | 1 | Receive-end event, sampled with `rx_eof` |
| air_valid | input | 1 | Air stream beat valid |
| air_data | input | DATA_W | Air stream byte |
| air_ready | output | 1 | Always 1; refused beats are discarded |
| sw_we | input | 1 | Software write enable |
| sw_addr | input | ADDR_W | Software write address |
| sw_wdata | input | DATA_W | Software write data |
| mem_air_we | output | 1 | Buffer air-port write enable |
| mem_air_addr | output | ADDR_W | Buffer air-port address |
| mem_air_wdata | output | DATA_W | Buffer air-port data |
| mem_sw_we | output | 1 | Buffer software-port write enable |
| mem_sw_addr | output | ADDR_W | Buffer software-port address |
| mem_sw_wdata | output | DATA_W | Buffer software-port data |
| air_permit | output | 1 | Current frame may write to the buffer |
| buf_locked | output | 1 | Lock in force |
| frame_dropped | output | 1 | One-cycle pulse for a blocked frame |
| frame_len | output | LEN_W | Length of the last admitted frame |

## Verification
Buffer writes and the software pass-through are combinational: they are due in the same cycle as the beat that causes them. The bench drives them just after a rising edge and compares them at the following falling edge. `air_permit` and `frame_dropped` come from registers loaded at the edge that captures `rx_sof`, so they are sampled at the falling edge after that one. `buf_locked` and `frame_len` follow the edge that captures `rx_eof` (or the drop of `prot_en`) in the same way. Expected buffer writes are queued as each beat is driven. A monitor compares every write as it happens and treats any write with nothing queued as a failure.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
  localparam int STATE_W = 5;
  localparam logic [STATE_W-1:0] ST_RX_PLAIN   = 5'h04;
  localparam logic [STATE_W-1:0] ST_RX_AUTOACK = 5'h0C;

  typedef enum logic {
    MODE_BASIC    = 1'b0,
    MODE_EXTENDED = 1'b1
  } lock_mode_e;
endpackage

// File: rtl/fbg_protect_ctrl.sv
module fbg_protect_ctrl
  import fbg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STATE_W-1:0] trx_state,
  input  logic               ext_mode,
  input  logic               prot_en,
  input  logic               frame_done,
  input  logic               crc_ok,
  input  logic               end_evt,
  output logic               lock_eff
);
  logic       rx_state_ok;
  logic       prot_active;
  logic       qualify;
  logic       lock_q;
  lock_mode_e mode;

  assign mode        = lock_mode_e'(ext_mode);
  assign rx_state_ok = (trx_state == ST_RX_PLAIN) || (trx_state == ST_RX_AUTOACK);
  assign prot_active = prot_en && rx_state_ok;
  assign qualify     = (mode == MODE_EXTENDED) ? end_evt : crc_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      lock_q <= 1'b0;
    else if (!prot_en)
      lock_q <= 1'b0;
    else if (frame_done && prot_active && qualify)
      lock_q <= 1'b1;
  end

  // lock is held but has no effect outside the receive states
  assign lock_eff = lock_q && rx_state_ok;

  AST_LOCK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !prot_en |=> !lock_q); // R7
  AST_LOCK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> $past(frame_done && prot_active)); // R3
  AST_BASIC_BAD_CRC: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !ext_mode && !crc_ok && !lock_q) |=> !lock_q); // R3
  AST_EXT_EVENT_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && prot_active && ext_mode && end_evt) |=> lock_q); // R4
endmodule

// File: rtl/fbg_frame_track.sv
module fbg_frame_track #(
  parameter int DEPTH  = 128,
  parameter int DATA_W = 8,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int LEN_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sof,
  input  logic              eof,
  input  logic              lock_eff,
  input  logic              air_valid,
  input  logic [DATA_W-1:0] air_data,
  output logic              permit,
  output logic              we,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wdata,
  output logic              dropped,
  output logic [LEN_W-1:0]  len,
  output logic              frame_done
);
  localparam logic [LEN_W-1:0] DEPTH_L = LEN_W'(DEPTH);

  logic             in_frame_q;
  logic             admit_q;
  logic             drop_q;
  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] len_q;

  assign permit     = in_frame_q && admit_q;
  assign we         = air_valid && permit && !sof && !eof && (cnt_q < DEPTH_L);
  assign addr       = cnt_q[ADDR_W-1:0];
  assign wdata      = air_data;
  assign frame_done = eof && !sof && in_frame_q && admit_q;
  assign dropped    = drop_q;
  assign len        = len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      admit_q    <= 1'b0;
      drop_q     <= 1'b0;
      cnt_q      <= '0;
      len_q      <= '0;
    end else if (sof) begin
      // admission is fixed once per frame, at its start
      in_frame_q <= 1'b1;
      admit_q    <= !lock_eff;
      drop_q     <= lock_eff;
      cnt_q      <= '0;
    end else begin
      drop_q <= 1'b0;
      if (eof && in_frame_q) begin
        in_frame_q <= 1'b0;
        if (admit_q) len_q <= cnt_q;
      end else if (we) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  AST_DROP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    drop_q |-> $past(sof && lock_eff)); // R6
  AST_LEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(frame_done) |-> $stable(len_q)); // R6
  AST_BLOCKED_NO_PERMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (sof && lock_eff) |=> !permit); // R5
  AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    len_q <= DEPTH_L); // R9
endmodule

// File: rtl/fbg_rx_guard.sv
module fbg_rx_guard
  import fbg_pkg::*;
#(
  parameter int DEPTH  = 128,
  parameter int DATA_W = 8,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int LEN_W  = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STATE_W-1:0] trx_state,
  input  logic               ext_mode,
  input  logic               prot_en,
  input  logic               rx_sof,
  input  logic               rx_eof,
  input  logic               rx_crc_ok,
  input  logic               rx_end_evt,
  input  logic               air_valid,
  input  logic [DATA_W-1:0]  air_data,
  output logic               air_ready,
  input  logic               sw_we,
  input  logic [ADDR_W-1:0]  sw_addr,
  input  logic [DATA_W-1:0]  sw_wdata,
  output logic               mem_air_we,
  output logic [ADDR_W-1:0]  mem_air_addr,
  output logic [DATA_W-1:0]  mem_air_wdata,
  output logic               mem_sw_we,
  output logic [ADDR_W-1:0]  mem_sw_addr,
  output logic [DATA_W-1:0]  mem_sw_wdata,
  output logic               air_permit,
  output logic               buf_locked,
  output logic               frame_dropped,
  output logic [LEN_W-1:0]   frame_len
);
  logic lock_eff;
  logic frame_done;

  fbg_protect_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .trx_state  (trx_state),
    .ext_mode   (ext_mode),
    .prot_en    (prot_en),
    .frame_done (frame_done),
    .crc_ok     (rx_crc_ok),
    .end_evt    (rx_end_evt),
    .lock_eff   (lock_eff)
  );

  fbg_frame_track #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .sof        (rx_sof),
    .eof        (rx_eof),
    .lock_eff   (lock_eff),
    .air_valid  (air_valid),
    .air_data   (air_data),
    .permit     (air_permit),
    .we         (mem_air_we),
    .addr       (mem_air_addr),
    .wdata      (mem_air_wdata),
    .dropped    (frame_dropped),
    .len        (frame_len),
    .frame_done (frame_done)
  );

  // the guard never stalls the receiver
  assign air_ready  = 1'b1;
  assign buf_locked = lock_eff;

  // the software port is never gated
  assign mem_sw_we    = sw_we;
  assign mem_sw_addr  = sw_addr;
  assign mem_sw_wdata = sw_wdata;

  AST_LOCKED_NO_AIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_locked && rx_sof) |=> !mem_air_we); // R5
endmodule

// File: tb/test_fbg_rx_guard.sv
module test_fbg_rx_guard;
  import fbg_pkg::*;
  localparam int DEPTH = 128;
  localparam int DW    = 8;
  localparam int AW    = 7;
  localparam int LW    = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [4:0]    trx_state = 5'h01;
  logic          ext_mode = 1'b0, prot_en = 1'b0;
  logic          rx_sof = 1'b0, rx_eof = 1'b0, rx_crc_ok = 1'b0, rx_end_evt = 1'b0;
  logic          air_valid = 1'b0;
  logic [DW-1:0] air_data = '0;
  logic          sw_we = 1'b0;
  logic [AW-1:0] sw_addr = '0;
  logic [DW-1:0] sw_wdata = '0;
  logic          air_ready, mem_air_we, mem_sw_we, air_permit, buf_locked, frame_dropped;
  logic [AW-1:0] mem_air_addr, mem_sw_addr;
  logic [DW-1:0] mem_air_wdata, mem_sw_wdata;
  logic [LW-1:0] frame_len;

  fbg_rx_guard #(.DEPTH(DEPTH), .DATA_W(DW)) i_fbg_rx_guard (
    .clk(clk), .rst_n(rst_n), .trx_state(trx_state), .ext_mode(ext_mode),
    .prot_en(prot_en), .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_crc_ok(rx_crc_ok),
    .rx_end_evt(rx_end_evt), .air_valid(air_valid), .air_data(air_data),
    .air_ready(air_ready), .sw_we(sw_we), .sw_addr(sw_addr), .sw_wdata(sw_wdata),
    .mem_air_we(mem_air_we), .mem_air_addr(mem_air_addr), .mem_air_wdata(mem_air_wdata),
    .mem_sw_we(mem_sw_we), .mem_sw_addr(mem_sw_addr), .mem_sw_wdata(mem_sw_wdata),
    .air_permit(air_permit), .buf_locked(buf_locked), .frame_dropped(frame_dropped),
    .frame_len(frame_len)
  );

  int n_checks = 0;
  int n_fail   = 0;
  logic [AW+DW-1:0] exp_q[$];
  logic [7:0] seed = 8'h11;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor: every air-side write must match the queue head
  always @(negedge clk) begin : mon
    logic [AW+DW-1:0] e;
    if (rst_n && mem_air_we) begin
      n_checks++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R5 unexpected write: actual %0h expected none",
                 {mem_air_addr, mem_air_wdata});
      end else begin
        e = exp_q.pop_front();
        if ({mem_air_addr, mem_air_wdata} !== e) begin
          n_fail++;
          $display("FAIL R9 write: actual %0h expected %0h",
                   {mem_air_addr, mem_air_wdata}, e);
        end
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic send_frame(input int nbeats, input bit crc, input bit evt,
                            input bit admit, input string req);
    rx_sof = 1'b1;
    step();
    rx_sof = 1'b0;
    @(negedge clk);
    check(req, "dropped after sof", frame_dropped, !admit);
    check(req, "permit after sof", air_permit, admit);
    step();
    @(negedge clk);
    check(req, "dropped one cycle", frame_dropped, 1'b0);
    step();
    for (int i = 0; i < nbeats; i++) begin
      seed = seed * 8'd5 + 8'd3;
      air_valid = 1'b1;
      air_data  = seed;
      if (admit && i < DEPTH) exp_q.push_back({i[AW-1:0], seed});
      step();
    end
    air_valid  = 1'b0;
    rx_eof     = 1'b1;
    rx_crc_ok  = crc;
    rx_end_evt = evt;
    step();
    rx_eof = 1'b0; rx_crc_ok = 1'b0; rx_end_evt = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "locked", buf_locked, 1'b0);
    check("R1", "permit", air_permit, 1'b0);
    check("R1", "dropped", frame_dropped, 1'b0);
    check("R1", "len", frame_len, 0);
    check("R1", "ready", air_ready, 1'b1);
    check("R1", "we", mem_air_we, 1'b0);
    step();
    rst_n = 1'b1;
    step();

    // R10: orphan beats and eof
    air_valid = 1'b1; air_data = 8'h3C; step(); step();
    air_valid = 1'b0; rx_eof = 1'b1; rx_crc_ok = 1'b1; step();
    rx_eof = 1'b0; rx_crc_ok = 1'b0;
    @(negedge clk);
    check("R10", "len", frame_len, 0);
    check("R10", "locked", buf_locked, 1'b0);

    // R2: enabled but not in a receive state
    prot_en = 1'b1; trx_state = 5'h01;
    send_frame(3, 1'b1, 1'b0, 1'b1, "R2");
    @(negedge clk);
    check("R2", "len", frame_len, 3);
    check("R2", "locked", buf_locked, 1'b0);
    step();
    send_frame(5, 1'b1, 1'b0, 1'b1, "R2");
    @(negedge clk);
    check("R2", "len overwrite", frame_len, 5);

    // R3: basic mode, checksum rule
    step();
    trx_state = ST_RX_PLAIN; ext_mode = 1'b0;
    send_frame(4, 1'b0, 1'b1, 1'b1, "R3");
    @(negedge clk);
    check("R3", "bad crc no lock", buf_locked, 1'b0);
    step();
    send_frame(6, 1'b1, 1'b0, 1'b1, "R3");
    @(negedge clk);
    check("R3", "good crc locks", buf_locked, 1'b1);
    check("R3", "len", frame_len, 6);

    // R5 / R6: blocked frame
    step();
    send_frame(3, 1'b1, 1'b0, 1'b0, "R5");
    @(negedge clk);
    check("R6", "len kept", frame_len, 6);
    check("R5", "still locked", buf_locked, 1'b1);

    // R8: software port while locked
    step();
    sw_we = 1'b1; sw_addr = 7'h05; sw_wdata = 8'hA5;
    @(negedge clk);
    check("R8", "sw we", mem_sw_we, 1'b1);
    check("R8", "sw addr", mem_sw_addr, 7'h05);
    check("R8", "sw data", mem_sw_wdata, 8'hA5);
    step();
    sw_we = 1'b0;

    // R7: suspend outside receive states, then restore
    trx_state = 5'h01;
    @(negedge clk);
    check("R7", "suspended", buf_locked, 1'b0);
    step();
    send_frame(2, 1'b0, 1'b0, 1'b1, "R7");
    @(negedge clk);
    check("R7", "len suspended", frame_len, 2);
    step();
    trx_state = ST_RX_PLAIN;
    @(negedge clk);
    check("R7", "restored", buf_locked, 1'b1);
    step();
    prot_en = 1'b0;
    @(negedge clk);
    check("R7", "held before edge", buf_locked, 1'b1);
    step();
    @(negedge clk);
    check("R7", "released", buf_locked, 1'b0);
    step();
    prot_en = 1'b1;
    send_frame(2, 1'b0, 1'b0, 1'b1, "R7");

    // R4: extended mode, event rule
    ext_mode = 1'b1; trx_state = ST_RX_AUTOACK;
    send_frame(3, 1'b1, 1'b0, 1'b1, "R4");
    @(negedge clk);
    check("R4", "crc ignored", buf_locked, 1'b0);
    step();
    send_frame(4, 1'b0, 1'b1, 1'b1, "R4");
    @(negedge clk);
    check("R4", "event locks", buf_locked, 1'b1);
    step();
    send_frame(2, 1'b0, 1'b1, 1'b0, "R6");
    @(negedge clk);
    check("R6", "len kept ext", frame_len, 4);
    step();
    prot_en = 1'b0;
    step();

    // R9: saturation at DEPTH
    send_frame(DEPTH + 2, 1'b1, 1'b0, 1'b1, "R9");
    @(negedge clk);
    check("R9", "len capped", frame_len, DEPTH);
    check("R9", "queue drained", exp_q.size(), 0);

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule